// File: doc/BRIEF.md
# Register Rename Status Table

This block sits at the issue stage of an out-of-order core that retires through a reorder buffer. For every architectural register it holds a pending flag and the reorder buffer entry number of the youngest in-flight instruction that will write that register. It also holds the architectural register values, which change only when an instruction retires.

At issue, each of the two source ports names a register and gets back one of three answers in the same cycle: the retired register value when no writer is pending, the finished result read from the reorder buffer when the pending writer is done, or the entry number to wait on when it is not. The reorder buffer itself lives outside. For each source the block drives the entry number to look up, and the reorder buffer returns a done flag and a result. A claim port marks an instruction's destination register as pending on a newly allocated entry. A retire port writes the register value and releases the pending flag. A flush input drops every pending flag after a misprediction.

Top module: `reg_status_table`

## Requirements
- R1: After reset every register reads as not pending with value 0, so every source returns valid with value 0.
- R2: A source naming a register that is not pending returns opnd_valid_o=1 and the retired register value on opnd_value_o.
- R3: A source naming a pending register drives that register's entry number on rob_tag_o. When rob_ready_i is 1 it returns opnd_valid_o=1 with opnd_value_o equal to rob_value_i.
- R4: A source naming a pending register whose entry has rob_ready_i=0 returns opnd_valid_o=0, with the entry number on opnd_tag_o.
- R5: A claim sets the register pending from the next cycle on, with the claimed entry number, and replaces any older entry number.
- R6: Register values change only on a retire. The retire writes commit_value_i into commit_reg_i at the clock edge, and finished results in the reorder buffer never reach the register values without it.
- R7: A retire clears the pending flag only when the retiring entry number equals the stored one. Otherwise the register stays pending on its newer entry, although the value is still written.
- R8: When a claim and a retire name the same register in the same cycle, the claim decides the next state: pending, with the claimed entry number.
- R9: A source naming the destination register of a claim in the same cycle sees the mapping from before that claim.
- R10: A flush clears every pending flag in one cycle, keeps register values, and overrides a claim in the same cycle.
- R11: The two source ports are looked up independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_idx_i | input | NUM_SRC x REG_W | Source register per lookup port |
| rob_tag_o | output | NUM_SRC x TAG_W | Reorder buffer entry to look up per port |
| rob_ready_i | input | NUM_SRC | Looked-up entry has finished |
| rob_value_i | input | NUM_SRC x DATA_W | Result held in the looked-up entry |
| opnd_valid_o | output | NUM_SRC | Operand value is available |
| opnd_value_o | output | NUM_SRC x DATA_W | Operand value when valid |
| opnd_tag_o | output | NUM_SRC x TAG_W | Entry to wait on when not valid, else 0 |
| claim_en_i | input | 1 | Destination claim strobe |
| claim_reg_i | input | REG_W | Destination register |
| claim_tag_i | input | TAG_W | Newly allocated entry number |
| commit_en_i | input | 1 | Retire strobe |
| commit_reg_i | input | REG_W | Register written at retire |
| commit_tag_i | input | TAG_W | Entry number that retires |
| commit_value_i | input | DATA_W | Value written at retire |
| flush_i | input | 1 | Drop all pending flags |

## Verification
The stimulus covers three cases for a source: a register with no writer, a pending writer whose entry has finished, and a pending writer whose entry has not. The reorder buffer model marks odd entry numbers as finished, so the entry number chosen in a claim decides which answer the source should get. Retires are tried with a matching and a stale entry number, and once in the same cycle as a claim to the same register. These cases separate a release keyed on the entry number from one keyed on the register alone, and show which of claim and retire takes priority. A flush that arrives with a claim, a same-cycle source and destination overlap, and a reset applied mid-run check the ordering cases.

// File: rtl/rst_pkg.sv
package rst_pkg;
  // where an operand comes from at issue
  typedef enum logic [1:0] {
    OPS_REG  = 2'd0,
    OPS_ROB  = 2'd1,
    OPS_WAIT = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/rst_status_array.sv
module rst_status_array #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             claim_en_i,
  input  logic [REG_W-1:0]                 claim_reg_i,
  input  logic [TAG_W-1:0]                 claim_tag_i,
  input  logic                             commit_en_i,
  input  logic [REG_W-1:0]                 commit_reg_i,
  input  logic [TAG_W-1:0]                 commit_tag_i,
  input  logic                             flush_i,
  output logic [NUM_REGS-1:0]              busy_o,
  output logic [NUM_REGS-1:0][TAG_W-1:0]   tag_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic             busy_q;
    logic [TAG_W-1:0] tag_q;
    logic             claim_hit;
    logic             release_hit;

    assign claim_hit   = claim_en_i && (claim_reg_i == REG_W'(r));
    assign release_hit = commit_en_i && (commit_reg_i == REG_W'(r)) && (tag_q == commit_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        tag_q  <= '0;
      end else if (flush_i) begin
        busy_q <= 1'b0;
      end else if (claim_hit) begin
        // a claim outranks a release of the same register
        busy_q <= 1'b1;
        tag_q  <= claim_tag_i;
      end else if (release_hit) begin
        busy_q <= 1'b0;
      end
    end

    assign busy_o[r] = busy_q;
    assign tag_o[r]  = tag_q;
  end
endmodule

// File: rtl/rst_regfile.sv
module rst_regfile #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_en_i,
  input  logic [REG_W-1:0]                 commit_reg_i,
  input  logic [DATA_W-1:0]                commit_value_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  value_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else if (commit_en_i && (commit_reg_i == REG_W'(r))) begin
        val_q <= commit_value_i;
      end
    end

    assign value_o[r] = val_q;
  end
endmodule

// File: rtl/rst_operand_sel.sv
module rst_operand_sel
  import rst_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32
) (
  input  logic [REG_W-1:0]                 src_idx_i,
  input  logic [NUM_REGS-1:0]              busy_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  rf_i,
  input  logic                             rob_ready_i,
  input  logic [DATA_W-1:0]                rob_value_i,
  output logic [TAG_W-1:0]                 rob_tag_o,
  output logic                             valid_o,
  output logic [DATA_W-1:0]                value_o,
  output logic [TAG_W-1:0]                 tag_o
);
  opnd_src_e         kind;
  logic              sel_busy;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_busy = busy_i[src_idx_i];
    sel_tag  = tag_i[src_idx_i];
    sel_val  = rf_i[src_idx_i];
    if (!sel_busy)        kind = OPS_REG;
    else if (rob_ready_i) kind = OPS_ROB;
    else                  kind = OPS_WAIT;
  end

  always_comb begin
    rob_tag_o = sel_tag;
    valid_o   = 1'b1;
    value_o   = '0;
    tag_o     = '0;
    unique case (kind)
      OPS_REG:  value_o = sel_val;
      OPS_ROB:  value_o = rob_value_i;
      default: begin
        valid_o = 1'b0;
        tag_o   = sel_tag;
      end
    endcase
  end
endmodule

// File: rtl/reg_status_table.sv
module reg_status_table #(
  parameter int NUM_REGS  = 16,
  parameter int ROB_DEPTH = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_SRC   = 2,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   src_idx_i,
  output logic [NUM_SRC-1:0][TAG_W-1:0]   rob_tag_o,
  input  logic [NUM_SRC-1:0]              rob_ready_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  rob_value_i,
  output logic [NUM_SRC-1:0]              opnd_valid_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  opnd_value_o,
  output logic [NUM_SRC-1:0][TAG_W-1:0]   opnd_tag_o,
  input  logic                            claim_en_i,
  input  logic [REG_W-1:0]                claim_reg_i,
  input  logic [TAG_W-1:0]                claim_tag_i,
  input  logic                            commit_en_i,
  input  logic [REG_W-1:0]                commit_reg_i,
  input  logic [TAG_W-1:0]                commit_tag_i,
  input  logic [DATA_W-1:0]               commit_value_i,
  input  logic                            flush_i
);
  logic [NUM_REGS-1:0]             busy_q;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;

  rst_status_array #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .TAG_W    (TAG_W)
  ) status_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .claim_en_i   (claim_en_i),
    .claim_reg_i  (claim_reg_i),
    .claim_tag_i  (claim_tag_i),
    .commit_en_i  (commit_en_i),
    .commit_reg_i (commit_reg_i),
    .commit_tag_i (commit_tag_i),
    .flush_i      (flush_i),
    .busy_o       (busy_q),
    .tag_o        (tag_q)
  );

  rst_regfile #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W)
  ) regfile_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .commit_en_i    (commit_en_i),
    .commit_reg_i   (commit_reg_i),
    .commit_value_i (commit_value_i),
    .value_o        (rf_q)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rst_operand_sel #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) sel_i (
      .src_idx_i   (src_idx_i[s]),
      .busy_i      (busy_q),
      .tag_i       (tag_q),
      .rf_i        (rf_q),
      .rob_ready_i (rob_ready_i[s]),
      .rob_value_i (rob_value_i[s]),
      .rob_tag_o   (rob_tag_o[s]),
      .valid_o     (opnd_valid_o[s]),
      .value_o     (opnd_value_o[s]),
      .tag_o       (opnd_tag_o[s])
    );
  end
endmodule

// File: rtl/rst_table_checker.sv
module rst_table_checker #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            claim_en_i,
  input logic [REG_W-1:0]                claim_reg_i,
  input logic [TAG_W-1:0]                claim_tag_i,
  input logic                            commit_en_i,
  input logic [REG_W-1:0]                commit_reg_i,
  input logic [TAG_W-1:0]                commit_tag_i,
  input logic [DATA_W-1:0]               commit_value_i,
  input logic                            flush_i,
  input logic [NUM_REGS-1:0]             busy_q,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q,
  input logic [NUM_REGS-1:0][DATA_W-1:0] rf_q,
  input logic [NUM_SRC-1:0]              rob_ready_i,
  input logic [NUM_SRC-1:0]              opnd_valid_o
);
  assert_claim_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_en_i && !flush_i |=>
      busy_q[$past(claim_reg_i)] && (tag_q[$past(claim_reg_i)] == $past(claim_tag_i)));

  assert_flush_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_q == '0));

  assert_release_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en_i && !flush_i && busy_q[commit_reg_i] && (tag_q[commit_reg_i] == commit_tag_i)
      && !(claim_en_i && (claim_reg_i == commit_reg_i))
    |=> !busy_q[$past(commit_reg_i)]);

  assert_keep_stale_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en_i && !flush_i && busy_q[commit_reg_i] && (tag_q[commit_reg_i] != commit_tag_i)
    |=> busy_q[$past(commit_reg_i)]);

  assert_claim_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_en_i && commit_en_i && !flush_i && (claim_reg_i == commit_reg_i)
    |=> busy_q[$past(claim_reg_i)]);

  assert_rf_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_en_i |=> $stable(rf_q));

  assert_rf_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en_i |=> (rf_q[$past(commit_reg_i)] == $past(commit_value_i)));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assert_wait_only_unready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !opnd_valid_o[s] |-> !rob_ready_i[s]);
  end
endmodule

bind reg_status_table rst_table_checker #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .TAG_W    (TAG_W),
  .DATA_W   (DATA_W),
  .NUM_SRC  (NUM_SRC)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .claim_en_i     (claim_en_i),
  .claim_reg_i    (claim_reg_i),
  .claim_tag_i    (claim_tag_i),
  .commit_en_i    (commit_en_i),
  .commit_reg_i   (commit_reg_i),
  .commit_tag_i   (commit_tag_i),
  .commit_value_i (commit_value_i),
  .flush_i        (flush_i),
  .busy_q         (busy_q),
  .tag_q          (tag_q),
  .rf_q           (rf_q),
  .rob_ready_i    (rob_ready_i),
  .opnd_valid_o   (opnd_valid_o)
);

// File: tb/reg_status_table_tb.sv
module reg_status_table_tb_top;
  localparam int NR = 16, RD = 16, DW = 32, NS = 2;
  localparam int RW = $clog2(NR), TW = $clog2(RD);

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NS-1:0][RW-1:0]   src_idx = '0;
  logic [NS-1:0][TW-1:0]   rob_tag;
  logic [NS-1:0]           rob_ready;
  logic [NS-1:0][DW-1:0]   rob_value;
  logic [NS-1:0]           o_valid;
  logic [NS-1:0][DW-1:0]   o_value;
  logic [NS-1:0][TW-1:0]   o_tag;
  logic                    claim_en = 1'b0;
  logic [RW-1:0]           claim_reg = '0;
  logic [TW-1:0]           claim_tag = '0;
  logic                    commit_en = 1'b0;
  logic [RW-1:0]           commit_reg = '0;
  logic [TW-1:0]           commit_tag = '0;
  logic [DW-1:0]           commit_value = '0;
  logic                    flush = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // reorder buffer model: odd entries finished, result 0xA0000000 | entry
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      rob_ready[s] = rob_tag[s][0];
      rob_value[s] = 32'hA000_0000 | DW'(rob_tag[s]);
    end
  end

  reg_status_table #(.NUM_REGS(NR), .ROB_DEPTH(RD), .DATA_W(DW), .NUM_SRC(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_idx_i(src_idx), .rob_tag_o(rob_tag),
    .rob_ready_i(rob_ready), .rob_value_i(rob_value), .opnd_valid_o(o_valid),
    .opnd_value_o(o_value), .opnd_tag_o(o_tag), .claim_en_i(claim_en),
    .claim_reg_i(claim_reg), .claim_tag_i(claim_tag), .commit_en_i(commit_en),
    .commit_reg_i(commit_reg), .commit_tag_i(commit_tag), .commit_value_i(commit_value),
    .flush_i(flush));

  typedef struct packed {
    logic          ce; logic [3:0] cr; logic [3:0] ct;
    logic          me; logic [3:0] mr; logic [3:0] mt; logic [31:0] mv;
    logic          fl; logic [3:0] s0; logic [3:0] s1;
    logic          ev0; logic [31:0] ed0;
    logic          ev1; logic [31:0] ed1;
  } vec_t;

  // expected fields show the state before this row's updates; ed = value if valid, else tag
  localparam vec_t VECS [12] = '{
    '{1'b0,4'd0,4'd0,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd3,4'd5,  1'b1,32'h0,        1'b1,32'h0},        // R1 R11
    '{1'b1,4'd3,4'd4,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd3,4'd3,  1'b1,32'h0,        1'b1,32'h0},        // R9
    '{1'b1,4'd5,4'd7,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd3,4'd5,  1'b0,32'd4,        1'b1,32'h0},        // R4 R9
    '{1'b0,4'd0,4'd0,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd5,4'd3,  1'b1,32'hA0000007, 1'b0,32'd4},        // R3 R4
    '{1'b1,4'd3,4'd6,  1'b1,4'd3,4'd4,32'h11,  1'b0,4'd3,4'd3,  1'b0,32'd4,        1'b0,32'd4},        // R8
    '{1'b0,4'd0,4'd0,  1'b1,4'd5,4'd7,32'h55,  1'b0,4'd3,4'd7,  1'b0,32'd6,        1'b1,32'h0},        // R5 R8
    '{1'b0,4'd0,4'd0,  1'b1,4'd3,4'd2,32'h33,  1'b0,4'd5,4'd3,  1'b1,32'h55,       1'b0,32'd6},        // R7 R2
    '{1'b1,4'd9,4'd9,  1'b0,4'd0,4'd0,32'h0,   1'b1,4'd3,4'd5,  1'b0,32'd6,        1'b1,32'h55},       // R7
    '{1'b1,4'd0,4'd3,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd3,4'd9,  1'b1,32'h33,       1'b1,32'h0},        // R10 R7
    '{1'b0,4'd0,4'd0,  1'b1,4'd0,4'd3,32'hF0,  1'b0,4'd0,4'd15, 1'b1,32'hA0000003, 1'b1,32'h0},        // R3
    '{1'b1,4'd15,4'd14,1'b0,4'd0,4'd0,32'h0,   1'b0,4'd0,4'd0,  1'b1,32'hF0,       1'b1,32'hF0},       // R6 R7
    '{1'b0,4'd0,4'd0,  1'b0,4'd0,4'd0,32'h0,   1'b0,4'd15,4'd8, 1'b0,32'd14,       1'b1,32'h0}         // R4 R5
  };

  function automatic string vec_req(int k);
    case (k)
      0: return "R1"; 1: return "R9"; 2: return "R4"; 3: return "R3";
      4: return "R8"; 5: return "R5"; 6: return "R7"; 7: return "R7";
      8: return "R10"; 9: return "R3"; 10: return "R6"; default: return "R4";
    endcase
  endfunction

  task automatic check_src(input int s, input logic ev, input logic [31:0] ed, input string req);
    logic [31:0] got;
    got = o_valid[s] ? o_value[s] : 32'(o_tag[s]);
    n_cmp++;
    if (o_valid[s] !== ev || got !== ed) begin
      n_bad++;
      $display("FAIL %s port%0d: valid=%0b data=%h, expected valid=%0b data=%h",
               req, s, o_valid[s], got, ev, ed);
    end
  endtask

  task automatic idle_inputs();
    claim_en = 1'b0; commit_en = 1'b0; flush = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 12; k++) begin
      claim_en = VECS[k].ce; claim_reg = VECS[k].cr; claim_tag = VECS[k].ct;
      commit_en = VECS[k].me; commit_reg = VECS[k].mr; commit_tag = VECS[k].mt;
      commit_value = VECS[k].mv; flush = VECS[k].fl;
      src_idx[0] = VECS[k].s0; src_idx[1] = VECS[k].s1;
      #1;
      check_src(0, VECS[k].ev0, VECS[k].ed0, vec_req(k));
      check_src(1, VECS[k].ev1, VECS[k].ed1, vec_req(k));
      step();
    end
    idle_inputs();

    // R6: a finished result in the reorder buffer never reaches register values without retire
    claim_en = 1'b1; claim_reg = 4'd2; claim_tag = 4'd1;
    step();
    idle_inputs();
    src_idx[0] = 4'd2; #1;
    check_src(0, 1'b1, 32'hA0000001, "R6");
    repeat (3) step();
    flush = 1'b1;
    step();
    idle_inputs(); #1;
    check_src(0, 1'b1, 32'h0, "R6");

    // R1: reset mid-run drops pending state and values
    step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    src_idx[0] = 4'd15; src_idx[1] = 4'd0; #1;
    check_src(0, 1'b1, 32'h0, "R1");
    check_src(1, 1'b1, 32'h0, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule